// File: doc/BRIEF.md
# Single-Line Write-Combining Buffer

This block gathers partial writes aimed at one memory line into a single line-sized write. It sits below the first-level cache, on the path that carries writes toward memory. Each incoming word write has a word address, a data word, per-byte enables and a tag bit that marks it as eligible for combining. Tagged writes are folded into a one-line holding register, with a per-byte valid mask. The held line is emitted as one masked line write when either of two things happens: a tagged write for a different line arrives, or the explicit flush input is raised.

Untagged writes never touch the held line. Each one leaves at once as its own masked line write and does not force the held contents out. Reads are never routed through this block, so a read of a line that is still held here sees stale memory. Both edges use ready/valid flow control. A stalled output back-pressures the input, so no write is dropped.

Top module: `wcb_line_buffer`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high and the buffer is empty, so a flush request emits nothing.
- R2: A tagged write with at least one enabled byte, to an empty buffer or to the held line, emits nothing. Its enabled bytes are added to the held mask, and a later byte overwrites an earlier one. Placement: line address = `in_waddr[WADDR_W-1:3]`, word slot = `in_waddr[2:0]`, and byte b of `in_data` (bits 8b+7:8b) lands in line byte 4*slot+b.
- R3: A tagged write to a line other than the held one causes the old contents to be emitted on the edge that accepts it. The buffer then holds only the new write's bytes, tagged with the new line.
- R4: An untagged write with at least one enabled byte is emitted on the accepting edge as its own line write, with only its own bytes in the mask. The held line, its mask and its data are left unchanged.
- R5: `flush_i` with a non-empty buffer emits the held line on the next edge and leaves the buffer empty. `flush_i` with an empty buffer emits nothing.
- R6: While `flush_i` is high and the buffer is non-empty, `in_ready` is low, so the flush is served before any new write.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_line`, `out_data` and `out_mask` hold steady. An input held during the stall is taken once the output frees.
- R8: A line write never carries an all-zero mask, and every data byte outside the mask is zero.
- R9: A write with all byte enables clear is accepted and has no effect on the output or on the held line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input write present |
| in_ready | output | 1 | Input write taken on this edge when high with in_valid |
| in_waddr | input | WADDR_W (30) | Word address of the write |
| in_data | input | WORD_BYTES*8 (32) | Write data word |
| in_be | input | WORD_BYTES (4) | Per-byte enables |
| in_tag | input | 1 | Write may be combined |
| flush_i | input | 1 | Request to drain the held line |
| out_valid | output | 1 | Line write present |
| out_ready | input | 1 | Sink takes the line write |
| out_line | output | LINE_A_W (27) | Line address of the write |
| out_data | output | LINE_BYTES*8 (256) | Line data, zero outside the mask |
| out_mask | output | LINE_BYTES (32) | Per-byte valid mask |

## Verification
A wrong held mask or held data stays out of sight until the next drain. It shows up at the ports only when a foreign-line tagged write or a flush emits the line, one edge after that event, as a wrong byte or wrong mask bit. A lost or spurious buffer-valid flag surfaces the same way: a flush that emits nothing when bytes were pending, or a drain with an empty mask. Flow-control faults are immediate: a stalled output that changes, or `in_ready` raised during a stall, is visible in the same cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int WCB_ADDR_W     = 32;
    localparam int WCB_WORD_BYTES = 4;
    localparam int WCB_LINE_BYTES = 32;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_MERGE,
        ACT_EVICT,
        ACT_BYPASS,
        ACT_FLUSH
    } wcb_act_e;

endpackage

// File: rtl/wcb_lane_place.sv
// Steers one data word and its byte enables into line-wide lanes.
module wcb_lane_place #(
    parameter int WORD_BYTES = 4,
    parameter int LINE_BYTES = 32,
    localparam int WORDS     = LINE_BYTES / WORD_BYTES,
    localparam int WSEL_W    = $clog2(WORDS)
) (
    input  logic [WSEL_W-1:0]       word_sel,
    input  logic [WORD_BYTES*8-1:0] word_data,
    input  logic [WORD_BYTES-1:0]   word_be,
    output logic [LINE_BYTES*8-1:0] line_data,
    output logic [LINE_BYTES-1:0]   line_mask
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic hit;
        assign hit = (word_sel == WSEL_W'(w));
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            localparam int L = w * WORD_BYTES + b;
            assign line_mask[L] = hit & word_be[b];
            assign line_data[L*8 +: 8] = (hit & word_be[b]) ? word_data[b*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/wcb_byte_merge.sv
// Overlays new bytes on held bytes, lane by lane.
module wcb_byte_merge #(
    parameter int LINE_BYTES = 32
) (
    input  logic [LINE_BYTES*8-1:0] old_data,
    input  logic [LINE_BYTES-1:0]   old_mask,
    input  logic [LINE_BYTES*8-1:0] new_data,
    input  logic [LINE_BYTES-1:0]   new_mask,
    output logic [LINE_BYTES*8-1:0] mrg_data,
    output logic [LINE_BYTES-1:0]   mrg_mask
);

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        assign mrg_data[i*8 +: 8] = new_mask[i] ? new_data[i*8 +: 8] : old_data[i*8 +: 8];
        assign mrg_mask[i]        = new_mask[i] | old_mask[i];
    end

endmodule

// File: rtl/wcb_line_buffer.sv
module wcb_line_buffer
    import wcb_pkg::*;
#(
    parameter int ADDR_W      = WCB_ADDR_W,
    parameter int WORD_BYTES  = WCB_WORD_BYTES,
    parameter int LINE_BYTES  = WCB_LINE_BYTES,
    localparam int BOFS_W     = $clog2(WORD_BYTES),
    localparam int OFS_W      = $clog2(LINE_BYTES),
    localparam int WSEL_W     = OFS_W - BOFS_W,
    localparam int WADDR_W    = ADDR_W - BOFS_W,
    localparam int LINE_A_W   = ADDR_W - OFS_W,
    localparam int WORD_W     = WORD_BYTES * 8,
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [WADDR_W-1:0]    in_waddr,
    input  logic [WORD_W-1:0]     in_data,
    input  logic [WORD_BYTES-1:0] in_be,
    input  logic                  in_tag,
    input  logic                  flush_i,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LINE_A_W-1:0]   out_line,
    output logic [LINE_W-1:0]     out_data,
    output logic [LINE_BYTES-1:0] out_mask
);

    typedef struct packed {
        logic                  out_v;
        logic [LINE_A_W-1:0]   out_line;
        logic [LINE_W-1:0]     out_data;
        logic [LINE_BYTES-1:0] out_mask;
        logic                  buf_v;
        logic [LINE_A_W-1:0]   buf_line;
        logic [LINE_W-1:0]     buf_data;
        logic [LINE_BYTES-1:0] buf_mask;
    } wcb_state_t;

    wcb_state_t st_d, st_q;
    wcb_act_e   act;

    logic [LINE_A_W-1:0]   in_line;
    logic [WSEL_W-1:0]     in_slot;
    logic [LINE_W-1:0]     plc_data, mrg_data;
    logic [LINE_BYTES-1:0] plc_mask, mrg_mask;
    logic                  slot_free, flush_go, accept, same_line;

    // Observation points for the bound checker.
    logic                  buf_valid_obs;
    logic [LINE_BYTES-1:0] buf_mask_obs;

    assign in_line = in_waddr[WADDR_W-1:WSEL_W];
    assign in_slot = in_waddr[WSEL_W-1:0];

    wcb_lane_place #(
        .WORD_BYTES (WORD_BYTES),
        .LINE_BYTES (LINE_BYTES)
    ) i_place (
        .word_sel  (in_slot),
        .word_data (in_data),
        .word_be   (in_be),
        .line_data (plc_data),
        .line_mask (plc_mask)
    );

    wcb_byte_merge #(
        .LINE_BYTES (LINE_BYTES)
    ) i_merge (
        .old_data (st_q.buf_data),
        .old_mask (st_q.buf_mask),
        .new_data (plc_data),
        .new_mask (plc_mask),
        .mrg_data (mrg_data),
        .mrg_mask (mrg_mask)
    );

    always_comb begin
        slot_free = !st_q.out_v || out_ready;
        flush_go  = flush_i && st_q.buf_v && slot_free;
        in_ready  = slot_free && !(flush_i && st_q.buf_v);
        accept    = in_valid && in_ready;
        same_line = st_q.buf_v && (st_q.buf_line == in_line);

        act = ACT_IDLE;
        if (flush_go) begin
            act = ACT_FLUSH;
        end else if (accept && (in_be != '0)) begin
            if (!in_tag)                      act = ACT_BYPASS;
            else if (!st_q.buf_v || same_line) act = ACT_MERGE;
            else                               act = ACT_EVICT;
        end

        st_d = st_q;
        if (st_q.out_v && out_ready) st_d.out_v = 1'b0;

        case (act)
            ACT_FLUSH: begin
                st_d.out_v    = 1'b1;
                st_d.out_line = st_q.buf_line;
                st_d.out_data = st_q.buf_data;
                st_d.out_mask = st_q.buf_mask;
                st_d.buf_v    = 1'b0;
                st_d.buf_data = '0;
                st_d.buf_mask = '0;
            end
            ACT_BYPASS: begin
                st_d.out_v    = 1'b1;
                st_d.out_line = in_line;
                st_d.out_data = plc_data;
                st_d.out_mask = plc_mask;
            end
            ACT_MERGE: begin
                st_d.buf_v    = 1'b1;
                st_d.buf_line = in_line;
                st_d.buf_data = mrg_data;
                st_d.buf_mask = mrg_mask;
            end
            ACT_EVICT: begin
                st_d.out_v    = 1'b1;
                st_d.out_line = st_q.buf_line;
                st_d.out_data = st_q.buf_data;
                st_d.out_mask = st_q.buf_mask;
                st_d.buf_line = in_line;
                st_d.buf_data = plc_data;
                st_d.buf_mask = plc_mask;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.out_v;
    assign out_line      = st_q.out_line;
    assign out_data      = st_q.out_data;
    assign out_mask      = st_q.out_mask;
    assign buf_valid_obs = st_q.buf_v;
    assign buf_mask_obs  = st_q.buf_mask;

endmodule

// File: rtl/wcb_line_buffer_chk.sv
module wcb_line_buffer_chk #(
    parameter int LINE_A_W   = 27,
    parameter int LINE_W     = 256,
    parameter int LINE_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  in_tag,
    input logic                  flush_i,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [LINE_A_W-1:0]   out_line,
    input logic [LINE_W-1:0]     out_data,
    input logic [LINE_BYTES-1:0] out_mask,
    input logic                  buf_valid_obs,
    input logic [LINE_BYTES-1:0] buf_mask_obs
);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_line)
                                       && $stable(out_data) && $stable(out_mask)));

    // R7
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));

    // R5
    flush_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && buf_valid_obs && (!out_valid || out_ready)) |=> (out_valid && !buf_valid_obs));

    // R6
    flush_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && buf_valid_obs) |-> !in_ready);

    // R4
    bypass_keeps_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_tag) |=> ($stable(buf_mask_obs) && $stable(buf_valid_obs)));

endmodule

bind wcb_line_buffer wcb_line_buffer_chk #(
    .LINE_A_W   (LINE_A_W),
    .LINE_W     (LINE_W),
    .LINE_BYTES (LINE_BYTES)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_tag        (in_tag),
    .flush_i       (flush_i),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_line      (out_line),
    .out_data      (out_data),
    .out_mask      (out_mask),
    .buf_valid_obs (buf_valid_obs),
    .buf_mask_obs  (buf_mask_obs)
);

// File: tb/test_wcb_line_buffer.sv
`timescale 1ns/1ps
module test_wcb_line_buffer;

    localparam int WADDR_W = 30;
    localparam int LA_W    = 27;
    localparam int LW      = 256;
    localparam int LB      = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [WADDR_W-1:0] in_waddr = '0;
    logic [31:0]     in_data = '0;
    logic [3:0]      in_be = '0;
    logic            in_tag = 1'b0;
    logic            flush_i = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [LA_W-1:0] out_line;
    logic [LW-1:0]   out_data;
    logic [LB-1:0]   out_mask;

    always #2 clk = ~clk;

    wcb_line_buffer i_wcb_line_buffer (
        .clk, .rst_n, .in_valid, .in_ready, .in_waddr, .in_data, .in_be,
        .in_tag, .flush_i, .out_valid, .out_ready, .out_line, .out_data, .out_mask
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference view of the held line, built from the requirements.
    logic            m_v = 1'b0;
    logic [LA_W-1:0] m_line = '0;
    logic [LW-1:0]   m_data = '0;
    logic [LB-1:0]   m_mask = '0;

    // Expected next output.
    logic            e_v;
    logic [LA_W-1:0] e_line;
    logic [LW-1:0]   e_data;
    logic [LB-1:0]   e_mask;

    typedef struct packed {
        logic               fl;
        logic               tg;
        logic [WADDR_W-1:0] wa;
        logic [31:0]        d;
        logic [3:0]         be;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 30'h40,  32'h11223344, 4'hF},
        '{1'b0, 1'b1, 30'h42,  32'hAABBCCDD, 4'h5},
        '{1'b0, 1'b1, 30'h40,  32'h55667788, 4'h2},
        '{1'b0, 1'b0, 30'h100, 32'h01020304, 4'hF},
        '{1'b0, 1'b1, 30'h47,  32'h9900EEFF, 4'h8},
        '{1'b0, 1'b1, 30'h80,  32'h0000BEEF, 4'h3},
        '{1'b1, 1'b0, 30'h0,   32'h0,        4'h0},
        '{1'b1, 1'b0, 30'h0,   32'h0,        4'h0},
        '{1'b0, 1'b1, 30'hC0,  32'hDEADBEEF, 4'h0},
        '{1'b1, 1'b0, 30'h0,   32'h0,        4'h0},
        '{1'b0, 1'b1, 30'hC1,  32'hCAFEF00D, 4'hC},
        '{1'b0, 1'b0, 30'hC1,  32'h12345678, 4'hF},
        '{1'b1, 1'b0, 30'h0,   32'h0,        4'h0}
    };

    task automatic place(input logic [WADDR_W-1:0] wa, input logic [31:0] d,
                         input logic [3:0] be,
                         output logic [LW-1:0] pd, output logic [LB-1:0] pm);
        pd = '0;
        pm = '0;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                pd[(wa[2:0]*4 + b)*8 +: 8] = d[b*8 +: 8];
                pm[wa[2:0]*4 + b] = 1'b1;
            end
        end
    endtask

    task automatic model_step(input logic fl, input logic tg, input logic [WADDR_W-1:0] wa,
                              input logic [31:0] d, input logic [3:0] be);
        logic [LW-1:0] pd;
        logic [LB-1:0] pm;
        place(wa, d, be, pd, pm);
        e_v = 1'b0; e_line = '0; e_data = '0; e_mask = '0;
        if (fl) begin
            if (m_v) begin
                e_v = 1'b1; e_line = m_line; e_data = m_data; e_mask = m_mask;
                m_v = 1'b0; m_data = '0; m_mask = '0;
            end
        end else if (be == 4'h0) begin
            e_v = 1'b0;
        end else if (!tg) begin
            e_v = 1'b1; e_line = wa[WADDR_W-1:3]; e_data = pd; e_mask = pm;
        end else if (m_v && (m_line != wa[WADDR_W-1:3])) begin
            e_v = 1'b1; e_line = m_line; e_data = m_data; e_mask = m_mask;
            m_line = wa[WADDR_W-1:3]; m_data = pd; m_mask = pm;
        end else begin
            for (int i = 0; i < LB; i++)
                if (pm[i]) m_data[i*8 +: 8] = pd[i*8 +: 8];
            m_mask = m_mask | pm;
            m_line = wa[WADDR_W-1:3];
            m_v = 1'b1;
        end
    endtask

    task automatic check_out(input string req);
        n_chk++;
        if (e_v) begin
            if (!(out_valid && out_line == e_line && out_data == e_data && out_mask == e_mask)) begin
                n_bad++;
                $display("FAIL %s: got v=%0b line=%h mask=%h data=%h, want v=1 line=%h mask=%h data=%h",
                         req, out_valid, out_line, out_mask, out_data, e_line, e_mask, e_data);
            end
        end else if (out_valid) begin
            n_bad++;
            $display("FAIL %s: got out_valid=1 line=%h mask=%h, want out_valid=0",
                     req, out_line, out_mask);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %0b want %0b", req, got, want);
        end
    endtask

    function automatic string row_req(input vec_t v);
        if (v.fl)           return "R5";
        if (v.be == 4'h0)   return "R9";
        if (!v.tg)          return "R4";
        return "R2/R3";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        e_v = 1'b0;
        check_out("R1");
        check_bit("R1 in_ready", in_ready, 1'b1);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        check_out("R1 empty flush");

        // Table walk, sink always ready
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            flush_i  = VEC[k].fl;
            in_valid = !VEC[k].fl;
            in_tag   = VEC[k].tg;
            in_waddr = VEC[k].wa;
            in_data  = VEC[k].d;
            in_be    = VEC[k].be;
            model_step(VEC[k].fl, VEC[k].tg, VEC[k].wa, VEC[k].d, VEC[k].be);
            @(negedge clk);
            in_valid = 1'b0;
            flush_i  = 1'b0;
            check_out(row_req(VEC[k]));
        end

        // R7: back-pressure with an eviction stuck at the output
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_tag = 1'b1; in_waddr = 30'h10; in_data = 32'hA1A2A3A4; in_be = 4'hF;
        model_step(1'b0, 1'b1, 30'h10, 32'hA1A2A3A4, 4'hF);
        @(negedge clk);
        check_out("R2 stall setup");
        in_waddr = 30'h18; in_data = 32'hB1B2B3B4; in_be = 4'h6;
        model_step(1'b0, 1'b1, 30'h18, 32'hB1B2B3B4, 4'h6);
        @(negedge clk);
        check_out("R3 evict");
        in_tag = 1'b0; in_waddr = 30'h205; in_data = 32'hC1C2C3C4; in_be = 4'h9;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check_bit("R7 in_ready during stall", in_ready, 1'b0);
            check_out("R7 held output");
        end
        out_ready = 1'b1;
        #0.5;
        check_bit("R7 in_ready on release", in_ready, 1'b1);
        model_step(1'b0, 1'b0, 30'h205, 32'hC1C2C3C4, 4'h9);
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R7 held input taken");

        // R6: flush wins over a simultaneous write
        @(negedge clk);
        flush_i = 1'b1;
        in_valid = 1'b1; in_tag = 1'b1; in_waddr = 30'h18; in_data = 32'hD1D2D3D4; in_be = 4'hF;
        #0.5;
        check_bit("R6 in_ready under flush", in_ready, 1'b0);
        model_step(1'b1, 1'b0, '0, '0, 4'h0);
        @(negedge clk);
        flush_i = 1'b0;
        check_out("R6 flush first");
        model_step(1'b0, 1'b1, 30'h18, 32'hD1D2D3D4, 4'hF);
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R6 write after flush");
        flush_i = 1'b1;
        model_step(1'b1, 1'b0, '0, '0, 4'h0);
        @(negedge clk);
        flush_i = 1'b0;
        check_out("R6 held write drained");

        // R8: final output after drain must be idle
        @(negedge clk);
        e_v = 1'b0;
        check_out("R8 idle");

        finish_run();
    end

endmodule